// File: doc/BRIEF.md
# Convolutional Deinterleaver with Sync Tracking

This block sits between a QAM symbol-to-byte mapper and a Reed-Solomon decoder. It accepts one byte on each cycle in which `inValid` is high. It finds the packet grid by looking for transport sync bytes. It then undoes a 12-branch convolutional interleave, so that the decoder receives whole 204-byte packets in their original order. A packet holds 188 data bytes and 16 parity bytes. The sync byte of each packet always sits on branch 0.

Lock is handled by a two-phase state machine. In the search phase, a candidate grid position becomes a lock after a programmable number of consecutive syncs spaced one packet apart. In the tracking phase, the block counts consecutive missing syncs at grid positions and falls back to search when a second programmable limit is reached. Both the normal sync value 0x47 and its bitwise inverse 0xB8 count as a sync.

Bytes are delivered only while tracking, and only once every branch delay line holds data that was written after the grid was found. Each delivered byte carries a valid strobe, and the first byte of each packet carries a start marker.

Top module: `conv_deinterleaver`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `syncLocked`, `outValid` and `outPktStart` are 0.
- R2: An input byte counts as a sync when it equals 0x47 or 0xB8. Both values count equally toward lock and toward clearing the missed-sync count.
- R3: In search, a sync received while no candidate exists starts a candidate and defines packet position 0. Each further sync exactly 204 strobes later adds one to the count. `syncLocked` rises in the cycle after the strobe that carries the `acqThresh`-th consecutive sync. An `acqThresh` of 0 behaves as 1.
- R4: While a candidate exists, sync-valued bytes at positions other than 0 are ignored. A non-sync byte at position 0 drops the candidate, and the next sync anywhere starts a new one.
- R5: While tracking, each non-sync byte at position 0 adds one to a missed count, and a sync at position 0 clears the count. `syncLocked` falls in the cycle after the strobe that carries the `lossThresh`-th consecutive miss. A `lossThresh` of 0 behaves as 1.
- R6: `outValid` is high in the cycle after a strobe, only while tracking. It starts with the byte that arrives 2244 strobes (11 packets) after the sync that caused lock, and stays high for every strobe after that until lock is lost.
- R7: A delivered byte at packet position p uses branch j = p mod 12. It equals the input byte received 204·j strobes earlier, which is j·17 visits of its own branch. Branch 0 passes the current byte with no delay.
- R8: `outPktStart` is high exactly when `outValid` is high for a byte at packet position 0.
- R9: A cycle with `inValid` low advances nothing. The next cycle shows `outValid` low and `syncLocked` unchanged, whatever is on `inData`.
- R10: While tracking, sync-valued bytes at positions other than 0 change neither the lock state nor the delivered data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acqThresh | input | 4 | Consecutive syncs needed to lock (0 acts as 1) |
| lossThresh | input | 4 | Consecutive missed syncs that drop lock (0 acts as 1) |
| inValid | input | 1 | Input byte strobe |
| inData | input | 8 | Input byte from the mapper |
| outValid | output | 1 | Deinterleaved byte valid |
| outData | output | 8 | Deinterleaved byte |
| outPktStart | output | 1 | First byte of a packet on the output |
| syncLocked | output | 1 | High while in the tracking phase |

## Verification
The cycle-level assertions cover several properties:
- the start marker never appears without a valid byte;
- a valid output only follows a strobe taken while locked;
- the lock flag holds still across idle cycles;
- lock rises only on a strobe carrying a sync value and falls only on a strobe carrying a non-sync value.

Some behaviours can only be shown by the bench's scenarios, because they depend on long histories:
- the exact strobe at which lock is gained or lost under different thresholds;
- candidate restarts and ignored off-grid syncs;
- the 2244-strobe fill delay;
- the per-branch delay of every delivered byte.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

  // strobes from the lock controller to the branch store
  typedef struct packed {
    logic step;     // a byte is consumed this cycle
    logic deliver;  // the byte read out this cycle is valid downstream
    logic first;    // the byte sits at packet position 0
  } cdiStrobe_t;

  typedef enum logic {
    PH_SEARCH = 1'b0,
    PH_TRACK  = 1'b1
  } cdiPhase_t;

  function automatic logic isSyncByte(input logic [7:0] b, input logic [7:0] s);
    return (b == s) || (b == ~s);
  endfunction

endpackage

// File: rtl/cdi_sync_fsm.sv
module cdi_sync_fsm
  import cdi_pkg::*;
#(
  parameter int          NUM_BRANCH = 12,
  parameter int          CELL_DEPTH = 17,
  parameter int          THR_W      = 4,
  parameter logic [7:0]  SYNC_BYTE  = 8'h47,
  localparam int         BR_W       = $clog2(NUM_BRANCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [THR_W-1:0] acqThresh,
  input  logic [THR_W-1:0] lossThresh,
  input  logic             inValid,
  input  logic [7:0]       inData,
  output cdiStrobe_t       strobe,
  output logic [BR_W-1:0]  branch,
  output logic             locked
);

  localparam int PKT_LEN = NUM_BRANCH * CELL_DEPTH;
  localparam int POS_W   = $clog2(PKT_LEN);
  localparam int FILL_W  = $clog2(NUM_BRANCH);
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(PKT_LEN - 1);
  localparam logic [BR_W-1:0]   BR_LAST   = BR_W'(NUM_BRANCH - 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(NUM_BRANCH - 1);
  localparam logic [FILL_W-1:0] FILL_NEAR = FILL_W'(NUM_BRANCH - 2);

  cdiPhase_t         phase;
  logic [POS_W-1:0]  pos;
  logic [BR_W-1:0]   br;
  logic [THR_W-1:0]  hitCnt;
  logic [THR_W-1:0]  missCnt;
  logic [FILL_W-1:0] fillCnt;

  logic             sawSync, atGrid, fillDone;
  logic [THR_W-1:0] needHits, needMiss;
  logic [THR_W:0]   hitNext, missNext;
  logic [POS_W-1:0] posAdv;
  logic [BR_W-1:0]  brAdv;

  always_comb begin
    sawSync  = isSyncByte(inData, SYNC_BYTE);
    atGrid   = (pos == '0);
    needHits = (acqThresh  == '0) ? THR_W'(1) : acqThresh;
    needMiss = (lossThresh == '0) ? THR_W'(1) : lossThresh;
    hitNext  = {1'b0, hitCnt}  + 1'b1;
    missNext = {1'b0, missCnt} + 1'b1;
    posAdv   = (pos == POS_LAST) ? '0 : pos + 1'b1;
    brAdv    = (br  == BR_LAST)  ? '0 : br  + 1'b1;
    // the byte that completes the eleventh packet start also opens delivery
    fillDone = (fillCnt == FILL_FULL) || (atGrid && fillCnt == FILL_NEAR);
  end

  always_comb begin
    strobe.step    = inValid;
    strobe.deliver = (phase == PH_TRACK) && fillDone;
    strobe.first   = atGrid;
    branch         = br;
    locked         = (phase == PH_TRACK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_SEARCH;
      pos     <= '0;
      br      <= '0;
      hitCnt  <= '0;
      missCnt <= '0;
      fillCnt <= '0;
    end else if (inValid) begin
      pos <= posAdv;
      br  <= brAdv;
      unique case (phase)
        PH_SEARCH: begin
          if (hitCnt != '0 && atGrid) begin
            if (sawSync) begin
              hitCnt <= hitNext[THR_W-1:0];
              if (hitNext >= {1'b0, needHits}) begin
                phase   <= PH_TRACK;
                missCnt <= '0;
                fillCnt <= '0;
              end
            end else begin
              hitCnt <= '0;
            end
          end else if (hitCnt == '0 && sawSync) begin
            // realign: this byte becomes packet position 0 on branch 0
            hitCnt <= THR_W'(1);
            pos    <= POS_W'(1);
            br     <= BR_W'(1);
            if (needHits == THR_W'(1)) begin
              phase   <= PH_TRACK;
              missCnt <= '0;
              fillCnt <= '0;
            end
          end
        end
        PH_TRACK: begin
          if (atGrid) begin
            if (fillCnt != FILL_FULL) fillCnt <= fillCnt + 1'b1;
            if (sawSync) begin
              missCnt <= '0;
            end else if (missNext >= {1'b0, needMiss}) begin
              phase  <= PH_SEARCH;
              hitCnt <= '0;
            end else begin
              missCnt <= missNext[THR_W-1:0];
            end
          end
        end
        default: phase <= PH_SEARCH;
      endcase
    end
  end

endmodule

// File: rtl/cdi_branch_store.sv
module cdi_branch_store
  import cdi_pkg::*;
#(
  parameter int  NUM_BRANCH = 12,
  parameter int  CELL_DEPTH = 17,
  parameter int  DATA_W     = 8,
  localparam int BR_W       = $clog2(NUM_BRANCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  cdiStrobe_t        ctl,
  input  logic [BR_W-1:0]   branch,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outPktStart
);

  // branch j holds j*CELL_DEPTH bytes; regions are packed back to back
  localparam int DEPTH  = CELL_DEPTH * NUM_BRANCH * (NUM_BRANCH - 1) / 2;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = $clog2((NUM_BRANCH - 1) * CELL_DEPTH);

  logic [ADDR_W-1:0] baseTab [NUM_BRANCH];
  logic [PTR_W-1:0]  lastTab [NUM_BRANCH];
  logic [PTR_W-1:0]  ringPtr [NUM_BRANCH];

  for (genvar g = 0; g < NUM_BRANCH; g++) begin : gBranch
    if (g == 0) begin : gDirect
      assign baseTab[g] = '0;
      assign lastTab[g] = '0;
    end else begin : gDelay
      assign baseTab[g] = ADDR_W'(CELL_DEPTH * g * (g - 1) / 2);
      assign lastTab[g] = PTR_W'(g * CELL_DEPTH - 1);
    end
  end

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] cellQ, bypassQ;
  logic              useBypass;
  logic              direct;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    direct = (branch == '0);
    addr   = baseTab[branch] + ADDR_W'(ringPtr[branch]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_BRANCH; k++) ringPtr[k] <= '0;
    end else if (ctl.step && !direct) begin
      if (ringPtr[branch] == lastTab[branch]) ringPtr[branch] <= '0;
      else                                    ringPtr[branch] <= ringPtr[branch] + 1'b1;
    end
  end

  // read-before-write: the oldest byte of the branch leaves as the new one enters
  always_ff @(posedge clk) begin
    if (ctl.step && !direct) begin
      cellQ       <= cells[addr];
      cells[addr] <= inData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid    <= 1'b0;
      outPktStart <= 1'b0;
      useBypass   <= 1'b0;
      bypassQ     <= '0;
    end else begin
      outValid    <= ctl.step && ctl.deliver;
      outPktStart <= ctl.step && ctl.deliver && ctl.first;
      if (ctl.step) begin
        useBypass <= direct;
        bypassQ   <= inData;
      end
    end
  end

  assign outData = useBypass ? bypassQ : cellQ;

endmodule

// File: rtl/conv_deinterleaver.sv
module conv_deinterleaver
  import cdi_pkg::*;
#(
  parameter int         NUM_BRANCH = 12,
  parameter int         CELL_DEPTH = 17,
  parameter logic [7:0] SYNC_BYTE  = 8'h47
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] acqThresh,
  input  logic [3:0] lossThresh,
  input  logic       inValid,
  input  logic [7:0] inData,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outPktStart,
  output logic       syncLocked
);

  localparam int BR_W = $clog2(NUM_BRANCH);

  cdiStrobe_t      strobe;
  logic [BR_W-1:0] branch;

  cdi_sync_fsm #(
    .NUM_BRANCH(NUM_BRANCH),
    .CELL_DEPTH(CELL_DEPTH),
    .THR_W     (4),
    .SYNC_BYTE (SYNC_BYTE)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .acqThresh (acqThresh),
    .lossThresh(lossThresh),
    .inValid   (inValid),
    .inData    (inData),
    .strobe    (strobe),
    .branch    (branch),
    .locked    (syncLocked)
  );

  cdi_branch_store #(
    .NUM_BRANCH(NUM_BRANCH),
    .CELL_DEPTH(CELL_DEPTH),
    .DATA_W    (8)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .ctl        (strobe),
    .branch     (branch),
    .inData     (inData),
    .outValid   (outValid),
    .outData    (outData),
    .outPktStart(outPktStart)
  );

endmodule

// File: rtl/cdi_checker.sv
module cdi_checker #(
  parameter logic [7:0] SYNC_BYTE = 8'h47
) (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic [7:0] inData,
  input logic       outValid,
  input logic       outPktStart,
  input logic       syncLocked
);

  logic syncIn;
  assign syncIn = (inData == SYNC_BYTE) || (inData == ~SYNC_BYTE);

  AST_START_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    outPktStart |-> outValid);  // R8
  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid));  // R9
  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(syncLocked));  // R6
  AST_LOCK_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(syncLocked));  // R9
  AST_LOCK_RISES_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(syncLocked) |-> $past(inValid && syncIn));  // R3
  AST_LOCK_FALLS_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    $fell(syncLocked) |-> $past(inValid && !syncIn));  // R5

endmodule

bind conv_deinterleaver cdi_checker #(.SYNC_BYTE(SYNC_BYTE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .inData     (inData),
  .outValid   (outValid),
  .outPktStart(outPktStart),
  .syncLocked (syncLocked)
);

// File: tb/conv_deinterleaver_tb.sv
module conv_deinterleaver_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 12;
  localparam int PKT  = 204;
  localparam int FILL = 2244;
  localparam int HIST = 4096;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] acqThresh = 4'd3;
  logic [3:0] lossThresh = 4'd2;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       outValid, outPktStart, syncLocked;
  logic [7:0] outData;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_deinterleaver u_dut (
    .clk(clk), .rst(rst), .acqThresh(acqThresh), .lossThresh(lossThresh),
    .inValid(inValid), .inData(inData), .outValid(outValid), .outData(outData),
    .outPktStart(outPktStart), .syncLocked(syncLocked)
  );

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  // requirement-level model state
  bit   mTrack = 0;
  int   mHits = 0, mMiss = 0, mPos = 0, mLockIdx = 0, n = 0;
  logic [7:0] hist [HIST];
  bit   expValid = 0, expStart = 0, expLocked = 0;
  logic [7:0] expData = 8'h00;
  int   payK = 0;
  bit   gapMode = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] payload();
    logic [7:0] b;
    b = 8'(payK * 73 + (payK >> 4) + 5);
    if (b == 8'h47 || b == 8'hB8) b = b ^ 8'h01;
    payK++;
    return b;
  endfunction

  task automatic modelStep(input logic [7:0] b);
    bit s;
    int aEff, bEff, j, idx;
    s    = (b == 8'h47) || (b == 8'hB8);
    aEff = (acqThresh == 0) ? 1 : int'(acqThresh);
    bEff = (lossThresh == 0) ? 1 : int'(lossThresh);
    hist[n % HIST] = b;
    expValid = mTrack && (n >= mLockIdx + FILL);
    expStart = expValid && (mPos == 0);
    j   = mPos % NB;
    idx = ((n - PKT * j) % HIST + HIST) % HIST;
    expData = hist[idx];
    if (!mTrack) begin
      if (mHits != 0 && mPos == 0) begin
        if (s) begin
          mHits++;
          if (mHits >= aEff) begin mTrack = 1; mMiss = 0; mLockIdx = n; end
        end else mHits = 0;
        mPos = (mPos + 1) % PKT;
      end else if (mHits == 0 && s) begin
        mHits = 1; mPos = 1;
        if (aEff == 1) begin mTrack = 1; mMiss = 0; mLockIdx = n; end
      end else mPos = (mPos + 1) % PKT;
    end else begin
      if (mPos == 0) begin
        if (s) mMiss = 0;
        else begin
          mMiss++;
          if (mMiss >= bEff) begin mTrack = 0; mHits = 0; end
        end
      end
      mPos = (mPos + 1) % PKT;
    end
    expLocked = mTrack;
    n++;
  endtask

  // compare the previous cycle's result, then drive the next input
  task automatic cycle(input logic v, input logic [7:0] b);
    @(negedge clk);
    check(syncLocked == expLocked, "R3/R5", "lock flag", syncLocked, expLocked);
    check(outValid == expValid, "R6", "valid", outValid, expValid);
    check(outPktStart == expStart, "R8", "packet start", outPktStart, expStart);
    if (expValid && outValid)
      check(outData == expData, "R7", "data", outData, expData);
    inValid = v;
    inData  = b;
    if (v) modelStep(b);
    else begin expValid = 0; expStart = 0; end
  endtask

  task automatic sendJunk(input int cnt);
    for (int i = 0; i < cnt; i++) cycle(1'b1, payload());
  endtask

  task automatic sendPacket(input logic [7:0] head, input int falseAt);
    cycle(1'b1, head);
    for (int i = 1; i < PKT; i++) begin
      if (gapMode && (i % 3 == 0)) cycle(1'b0, 8'hB8);  // R9 idle with sync-valued data
      cycle(1'b1, (i == falseAt) ? 8'h47 : payload());
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errs++;
      $display("FAIL R6 watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(syncLocked == 0 && outValid == 0 && outPktStart == 0, "R1", "in reset",
          {syncLocked, outValid, outPktStart}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(syncLocked == 0 && outValid == 0 && outPktStart == 0, "R1", "after reset",
          {syncLocked, outValid, outPktStart}, 0);

    // scenario 1: alpha 3, beta 2, mixed sync polarities (R2, R3)
    sendJunk(7);
    sendPacket(8'h47, 0);
    sendPacket(8'hB8, 0);
    check(syncLocked == 0, "R3", "two syncs not enough", syncLocked, 0);
    sendPacket(8'h47, 0);
    check(syncLocked == 1, "R2", "lock with inverted sync in run", syncLocked, 1);
    for (int p = 0; p < 13; p++) sendPacket((p % 4 == 1) ? 8'hB8 : 8'h47, (p % 3 == 0) ? 60 : 0); // R10
    check(syncLocked == 1, "R10", "off-grid syncs ignored", syncLocked, 1);
    gapMode = 1;
    for (int p = 0; p < 2; p++) sendPacket(8'h47, 0);  // R9 gaps
    gapMode = 0;
    sendPacket(8'h12, 0);
    sendPacket(8'hB8, 0);
    sendPacket(8'h12, 0);
    check(syncLocked == 1, "R5", "isolated misses keep lock", syncLocked, 1);
    sendPacket(8'h12, 0);
    check(syncLocked == 0, "R5", "second consecutive miss", syncLocked, 0);
    cycle(1'b0, 8'h47);
    cycle(1'b0, 8'h47);
    check(outValid == 0 && syncLocked == 0, "R9", "idle cycles", outValid, 0);

    // scenario 2: thresholds of zero act as one
    acqThresh = 4'd0; lossThresh = 4'd0;
    sendJunk(33);
    sendPacket(8'hB8, 0);
    check(syncLocked == 1, "R3", "zero acquire count", syncLocked, 1);
    for (int p = 0; p < 12; p++) sendPacket(8'h47, 0);
    sendPacket(8'h12, 0);
    check(syncLocked == 0, "R5", "zero loss count", syncLocked, 0);

    // scenario 3: candidate handling (R4)
    acqThresh = 4'd2; lossThresh = 4'd1;
    sendJunk(20);
    cycle(1'b1, 8'h47);
    sendJunk(99);
    cycle(1'b1, 8'h47);
    sendJunk(103);
    sendPacket(8'h47, 0);
    check(syncLocked == 1, "R4", "off-grid sync ignored in search", syncLocked, 1);
    sendPacket(8'h12, 0);
    sendJunk(5);
    sendPacket(8'h47, 0);
    sendPacket(8'h12, 0);
    sendPacket(8'h47, 0);
    check(syncLocked == 0, "R4", "grid miss drops candidate", syncLocked, 0);
    sendPacket(8'h47, 0);
    check(syncLocked == 1, "R4", "new candidate locks", syncLocked, 1);
    for (int p = 0; p < 12; p++) sendPacket(8'hB8, 0);
    cycle(1'b0, 8'h00);
    cycle(1'b0, 8'h00);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule